// File: doc/BRIEF.md
# Four-Phase Bus Access Sequencer

This block is the processor-side engine for a shared 16-bit bus that carries the address and then the data on the same lines. Each bus cycle has four phases, P1 to P4, and the block advances one phase per clock. A free-running two-bit counter tracks the phase. A core asks for one read or one write through a small request port. The block then drives the address, raises an address strobe and enters the data phase. A read uses a read strobe with the bus released. A write uses a write strobe with the write data driven. The data phase repeats until the addressed unit acknowledges.

The lines are modelled with a separate output value, an output-enable and an input value in place of tri-state pins. An external bus master can freeze an access by holding the hold input high. The core sees a one-phase completion pulse. For a read, the captured word is valid from that pulse until the next read completes.

Top module: `bus_access_seq`

## Requirements
- R1: While `rst_n` is low, and on the first phase after it is released, `addr_strobe`, `rd_strobe`, `wr_strobe`, `bus_oe`, `done` and `req_ready` are low and `phase_o` is 0. Asserting reset in the middle of an access clears all strobes at once.
- R2: `phase_o` encodes P1..P4 as 0..3. Out of reset it steps by one per clock and wraps from 3 to 0.
- R3: A request is taken only when the block is idle and in P4, which `req_ready` shows. `req_valid` in any other phase, or during an access, has no effect on the bus.
- R4: In the access's first cycle (the address cycle), the address drives the bus from P1 with `bus_oe` high. `addr_strobe` rises at P2 of that cycle and stays high until P2 of the termination cycle.
- R5: On a read, `bus_oe` falls and `rd_strobe` rises at P2 of the cycle after the address cycle. On repeated data cycles, `rd_strobe` stays high in every phase.
- R6: A read completes when `ack_i` is high and `hold_i` is low at P3: the block captures `bus_in` in that phase. The next cycle is the termination cycle. There `addr_strobe` and `rd_strobe` fall at P2, and `rd_data` holds the captured word.
- R7: If `ack_i` is low at P3 of a data cycle, the whole data cycle repeats with the strobes unchanged and nothing captured.
- R8: If `hold_i` is high at P3 of a data cycle, the access waits with no capture and no completion, even if `ack_i` is high. It resumes once `hold_i` is low at P3.
- R9: On a write, the write data is driven and `wr_strobe` rises at P1 of the cycle after the address cycle. After an acknowledge, `addr_strobe` falls at P2 of the termination cycle and `wr_strobe` falls at P4. `bus_oe` falls at the following P1.
- R10: `done` is high for exactly one clock, at P4 of the termination cycle, and never in any other phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Phase clock, one edge per phase |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Core asks for an access |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Access address |
| req_wdata | input | 16 | Write data |
| req_ready | output | 1 | Request is taken at this clock |
| done | output | 1 | One-phase completion pulse |
| rd_data | output | 16 | Last word read |
| bus_out | output | 16 | Value driven onto the shared lines |
| bus_oe | output | 1 | Drive enable for the shared lines |
| bus_in | input | 16 | Value seen on the shared lines |
| addr_strobe | output | 1 | Address valid / access in progress |
| rd_strobe | output | 1 | Read data wanted from the addressed unit |
| wr_strobe | output | 1 | Write data is on the lines |
| ack_i | input | 1 | Acknowledge from the addressed unit |
| hold_i | input | 1 | External master asks that the bus be frozen |
| phase_o | output | 2 | Current phase, 0..3 for P1..P4 |

## Verification
The hardest situation to reach is a data cycle that has to be retried because of a hold while the acknowledge is already high, followed by retries caused by a missing acknowledge. During those cycles `bus_in` carries a decoy word, so a capture too early would show up. The bench sweeps both directions over zero to two held cycles combined with zero to two unacknowledged cycles. It predicts every strobe in every phase from the cycle index alone and keeps `req_valid` high with a foreign address throughout. One read is cut short by reset in the middle of its repeat phase.

// File: rtl/bas_pkg.sv
package bas_pkg;
  typedef enum logic [1:0] {PH1 = 2'd0, PH2 = 2'd1, PH3 = 2'd2, PH4 = 2'd3} phase_t;
  typedef enum logic [1:0] {ST_IDLE, ST_ADDR, ST_DATA, ST_TERM} seq_t;
endpackage

// File: rtl/bas_phase_ctr.sv
module bas_phase_ctr
  import bas_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  output phase_t ph
);
  logic [1:0] ph_inc;
  phase_t     ph_d;

  always_comb begin
    ph_inc = ph + 2'd1;
    ph_d   = phase_t'(ph_inc);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ph <= PH1;
    else        ph <= ph_d;
  end
endmodule

// File: rtl/bas_seq_fsm.sv
module bas_seq_fsm
  import bas_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  phase_t        ph,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [DW-1:0] bus_in,
  input  logic          ack_i,
  input  logic          hold_i,
  output logic          req_ready,
  output seq_t          st,
  output logic          wr_q,
  output logic          rpt_q,
  output logic [DW-1:0] addr_q,
  output logic [DW-1:0] wdata_q,
  output logic [DW-1:0] rdata_q
);
  seq_t st_d;
  logic rpt_d, ok_q, ok_d;
  logic take_en, cap_en;

  always_comb begin
    st_d      = st;
    rpt_d     = rpt_q;
    ok_d      = ok_q;
    take_en   = 1'b0;
    cap_en    = 1'b0;
    req_ready = (st == ST_IDLE) && (ph == PH4);
    case (st)
      ST_IDLE: if (req_ready && req_valid) begin
        take_en = 1'b1;
        st_d    = ST_ADDR;
      end
      ST_ADDR: if (ph == PH4) begin
        st_d  = ST_DATA;
        rpt_d = 1'b0;
        ok_d  = 1'b0;
      end
      ST_DATA: begin
        if (ph == PH3) begin
          ok_d   = ack_i && !hold_i;
          cap_en = ack_i && !hold_i && !wr_q;
        end
        if (ph == PH4) begin
          if (ok_q) st_d = ST_TERM;
          else      rpt_d = 1'b1;
        end
      end
      ST_TERM: if (ph == PH4) begin
        st_d  = ST_IDLE;
        rpt_d = 1'b0;
        ok_d  = 1'b0;
      end
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= ST_IDLE;
      rpt_q <= 1'b0;
      ok_q  <= 1'b0;
      wr_q  <= 1'b0;
    end else begin
      st    <= st_d;
      rpt_q <= rpt_d;
      ok_q  <= ok_d;
      if (take_en) wr_q <= req_write;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      if (take_en) begin
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (cap_en) rdata_q <= bus_in;
    end
  end
endmodule

// File: rtl/bas_strobe_dec.sv
module bas_strobe_dec
  import bas_pkg::*;
#(
  parameter int DW = 16
) (
  input  seq_t          st,
  input  phase_t        ph,
  input  logic          wr_q,
  input  logic          rpt_q,
  input  logic [DW-1:0] addr_q,
  input  logic [DW-1:0] wdata_q,
  output logic          addr_strobe,
  output logic          rd_strobe,
  output logic          wr_strobe,
  output logic          bus_oe,
  output logic [DW-1:0] bus_out,
  output logic          done
);
  logic in_addr, in_data, in_term, p1;

  always_comb begin
    in_addr     = (st == ST_ADDR);
    in_data     = (st == ST_DATA);
    in_term     = (st == ST_TERM);
    p1          = (ph == PH1);
    addr_strobe = (in_addr && !p1) || in_data || (in_term && p1);
    rd_strobe   = !wr_q && ((in_data && (!p1 || rpt_q)) || (in_term && p1));
    wr_strobe   = wr_q && (in_data || (in_term && ph != PH4));
    bus_oe      = in_addr || (wr_q ? (in_data || in_term) : (in_data && p1 && !rpt_q));
    bus_out     = (wr_q && !in_addr) ? wdata_q : addr_q;
    done        = in_term && (ph == PH4);
  end
endmodule

// File: rtl/bus_access_seq.sv
module bus_access_seq
  import bas_pkg::*;
#(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [DW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          done,
  output logic [DW-1:0] rd_data,
  output logic [DW-1:0] bus_out,
  output logic          bus_oe,
  input  logic [DW-1:0] bus_in,
  output logic          addr_strobe,
  output logic          rd_strobe,
  output logic          wr_strobe,
  input  logic          ack_i,
  input  logic          hold_i,
  output logic [1:0]    phase_o
);
  logic [1:0]    rst_sync;
  logic          rst_q;
  phase_t        ph;
  seq_t          st;
  logic          wr_q, rpt_q;
  logic [DW-1:0] addr_q, wdata_q;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q   = rst_sync[1];
  assign phase_o = ph;

  bas_phase_ctr u_ph (.clk(clk), .rst_n(rst_q), .ph(ph));

  bas_seq_fsm #(.DW(DW)) u_fsm (
    .clk(clk), .rst_n(rst_q), .ph(ph),
    .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata),
    .bus_in(bus_in), .ack_i(ack_i), .hold_i(hold_i),
    .req_ready(req_ready), .st(st), .wr_q(wr_q), .rpt_q(rpt_q),
    .addr_q(addr_q), .wdata_q(wdata_q), .rdata_q(rd_data)
  );

  bas_strobe_dec #(.DW(DW)) u_dec (
    .st(st), .ph(ph), .wr_q(wr_q), .rpt_q(rpt_q),
    .addr_q(addr_q), .wdata_q(wdata_q),
    .addr_strobe(addr_strobe), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
    .bus_oe(bus_oe), .bus_out(bus_out), .done(done)
  );
endmodule

// File: rtl/bas_checker.sv
module bas_checker (
  input logic       clk,
  input logic       rst_q,
  input logic [1:0] phase_o,
  input logic       addr_strobe,
  input logic       rd_strobe,
  input logic       wr_strobe,
  input logic       bus_oe,
  input logic       done,
  input logic       req_ready
);
  logic seen_q;
  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) seen_q <= 1'b0;
    else        seen_q <= 1'b1;
  end

  a_r2_phase_step: assert property (@(posedge clk) disable iff (!rst_q)
    seen_q |-> (2'(phase_o - $past(phase_o)) == 2'd1));
  a_r10_done_p4: assert property (@(posedge clk) disable iff (!rst_q)
    done |-> phase_o == 2'd3);
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_q)
    done |=> !done);
  a_r4_strobe_rise_p2: assert property (@(posedge clk) disable iff (!rst_q)
    $rose(addr_strobe) |-> phase_o == 2'd1);
  a_r6_strobe_fall_p2: assert property (@(posedge clk) disable iff (!rst_q)
    $fell(addr_strobe) |-> phase_o == 2'd1);
  a_r5_one_direction: assert property (@(posedge clk) disable iff (!rst_q)
    !(rd_strobe && wr_strobe));
  a_r9_wr_drives: assert property (@(posedge clk) disable iff (!rst_q)
    wr_strobe |-> bus_oe);
  a_r3_ready_idle: assert property (@(posedge clk) disable iff (!rst_q)
    req_ready |-> !addr_strobe && !rd_strobe && !wr_strobe && !bus_oe);
endmodule

bind bus_access_seq bas_checker u_chk (
  .clk(clk), .rst_q(rst_q), .phase_o(phase_o),
  .addr_strobe(addr_strobe), .rd_strobe(rd_strobe), .wr_strobe(wr_strobe),
  .bus_oe(bus_oe), .done(done), .req_ready(req_ready)
);

// File: tb/sim_bus_access_seq.sv
`timescale 1ns/1ps
module sim_bus_access_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_write;
  logic [15:0] req_addr, req_wdata, bus_in;
  logic        ack_i, hold_i;
  logic        req_ready, done, bus_oe, addr_strobe, rd_strobe, wr_strobe;
  logic [15:0] rd_data, bus_out;
  logic [1:0]  phase_o;
  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  bus_access_seq u0 (.*);

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    step(); step();
    chk("R1 strobes in reset", {12'd0, addr_strobe, rd_strobe, wr_strobe, bus_oe}, 16'd0);
    rst_n = 1'b1;
    step();
    chk("R1 phase after release", {14'd0, phase_o}, 16'd0);
    chk("R1 outputs after release", {11'd0, addr_strobe, rd_strobe, wr_strobe, bus_oe, done}, 16'd0);
    chk("R1 ready after release", {15'd0, req_ready}, 16'd0);
  endtask

  task automatic wait_p4();
    while (phase_o != 2'd3) step();
  endtask

  // one complete access with nb held and nn unacknowledged data cycles
  task automatic run(input bit wr, input logic [15:0] a, input logic [15:0] wd,
                     input logic [15:0] rd, input int nb, input int nn);
    int dlast = nb + nn + 1;
    int tcyc  = dlast + 1;
    wait_p4();
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = wd;
    chk("R3 ready at idle P4", {15'd0, req_ready}, 16'd1);
    step();
    req_addr = ~a; req_wdata = ~wd; req_write = ~wr;  // foreign request held high
    for (int c = 0; c <= tcyc; c++) begin
      for (int p = 0; p < 4; p++) begin
        string tg;
        bit e_sync, e_rd, e_wr, e_oe, e_done;
        if (p == 0) begin
          hold_i = (c >= 1 && c <= nb);
          ack_i  = (c >= 1 && c <= nb) || (c == dlast);
          bus_in = (c == dlast) ? rd : ~rd;
        end
        tg = (c >= 1 && c <= nb) ? "R8" : (c > nb && c < dlast) ? "R7" : "";
        e_sync = (c == 0) ? (p >= 1) : (c <= dlast) ? 1'b1 : (p == 0);
        e_done = (c == tcyc) && (p == 3);
        if (!wr) begin
          e_rd = (c == 0) ? 1'b0 : (c == 1) ? (p >= 1) : (c <= dlast) ? 1'b1 : (p == 0);
          e_wr = 1'b0;
          e_oe = (c == 0) || (c == 1 && p == 0);
        end else begin
          e_rd = 1'b0;
          e_wr = (c == 0) ? 1'b0 : (c <= dlast) ? 1'b1 : (p <= 2);
          e_oe = 1'b1;
        end
        chk({tg, " R4 addr_strobe"}, {15'd0, addr_strobe}, {15'd0, e_sync});
        chk({tg, " R5 rd_strobe"}, {15'd0, rd_strobe}, {15'd0, e_rd});
        chk({tg, " R9 wr_strobe"}, {15'd0, wr_strobe}, {15'd0, e_wr});
        chk({tg, " R9 bus_oe"}, {15'd0, bus_oe}, {15'd0, e_oe});
        chk({tg, " R10 done"}, {15'd0, done}, {15'd0, e_done});
        chk({tg, " R3 ready busy"}, {15'd0, req_ready}, 16'd0);
        chk("R2 phase", {14'd0, phase_o}, 16'(p));
        if (e_oe) chk("R4 bus_out", bus_out, (wr && c > 0) ? wd : a);
        if (e_done && !wr) chk("R6 rd_data", rd_data, rd);
        if (e_done) req_valid = 1'b0;
        step();
      end
    end
    hold_i = 1'b0; ack_i = 1'b0;
    chk("R9 released after access", {13'd0, bus_oe, addr_strobe, done}, 16'd0);
  endtask

  initial begin
    req_valid = 0; req_write = 0; req_addr = 0; req_wdata = 0;
    bus_in = 0; ack_i = 0; hold_i = 0;
    do_reset();
    // R3: requests outside idle P4 are not taken
    wait_p4(); step();
    req_valid = 1'b1; req_addr = 16'h5A5A;
    for (int i = 0; i < 3; i++) begin
      chk("R3 ready low off P4", {15'd0, req_ready}, 16'd0);
      step();
    end
    req_valid = 1'b0;
    for (int i = 0; i < 4; i++) begin
      chk("R3 ignored request", {14'd0, addr_strobe, bus_oe}, 16'd0);
      step();
    end
    for (int w = 0; w < 2; w++)
      for (int nb = 0; nb < 3; nb++)
        for (int nn = 0; nn < 3; nn++) begin
          logic [15:0] a = 16'h1000 + 16'(w * 9 + nb * 3 + nn) * 16'h0123;
          run(w[0], a, a ^ 16'hC3A5, {a[7:0], a[15:8]}, nb, nn);
        end
    // R1: reset in the middle of a read repeat
    wait_p4();
    req_valid = 1'b1; req_write = 1'b0; req_addr = 16'h7777;
    step(); req_valid = 1'b0;
    for (int i = 0; i < 10; i++) step();
    chk("R1 mid read active", {15'd0, rd_strobe}, 16'd1);
    rst_n = 1'b0; #0.5;
    chk("R1 async clear", {12'd0, addr_strobe, rd_strobe, wr_strobe, bus_oe}, 16'd0);
    step();
    rst_n = 1'b1; step();
    chk("R1 idle after mid reset", {14'd0, addr_strobe, rd_strobe}, 16'd0);
    run(1'b0, 16'h2468, 16'h0, 16'hBEEF, 0, 1);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #80000;
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule